// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a Bulk OUT Endpoint

This block sits between a USB serial engine and a CPU for one bulk OUT endpoint. It holds two packet buffers of up to 64 bytes each. The serial engine streams bytes into one buffer while the CPU drains the other. A packet is closed by an end strobe or thrown away by an error strobe. The block tells the serial engine whether a free buffer is waiting, and the engine NAKs the host when none is.

The CPU sees one buffer at a time. A size register shows how many valid bytes that buffer holds, and a flag shows that it holds a packet. The CPU reads bytes in order with a single read strobe. When it has finished with a packet it pulses a read-finish trigger. The trigger releases that buffer back to the USB side, turns the CPU's view to the other buffer, and loads that buffer's byte count into the size register.

The CPU's view never moves on its own. A clear input empties both buffers, for example after a cable disconnect. The block ignores a clear while a packet is still arriving.

Top module: `ob_pingpong_rx`

## Requirements
- R1: After reset, `usb_buf_avail` is 1, `cpu_data_avail` is 0, `cpu_rx_size` is 0 and `cpu_rd_err` is 0.
- R2: A packet completed with `usb_pkt_end` into the buffer the CPU is viewing sets `cpu_data_avail` and shows its byte count on `cpu_rx_size` after the same clock edge. Each `cpu_rd_en` cycle returns the next byte of that packet in arrival order on `cpu_rd_data`, one cycle later.
- R3: The USB side fills the two buffers in turn. A second packet finishing while the CPU still holds the first leaves `cpu_rx_size` unchanged. The next read-finish shows the second packet's count.
- R4: While the buffer the USB side would fill next is still held, `usb_buf_avail` is 0. Bytes and end strobes arriving in that state are discarded.
- R5: A read when `cpu_data_avail` is 0, or once the packet's `cpu_rx_size` bytes have been read, returns 0 and sets `cpu_rd_err`. The error flag stays set until a read-finish or an accepted clear.
- R6: A pulse of `cpu_rd_done` while `cpu_data_avail` is 1 frees the viewed buffer for reception and switches the view to the other buffer. While `cpu_data_avail` is 0 the pulse has no effect.
- R7: A packet that ends with `usb_pkt_err` is dropped, and its buffer stays free. The next packet goes into that same buffer.
- R8: A buffer stores at most 64 bytes. Bytes after the 64th of a packet are dropped, and `cpu_rx_size` never exceeds 64.
- R9: A `fifo_clear` pulse while no packet is partly received empties both buffers, clears `cpu_rd_err`, and restarts both sides at buffer 0. A clear arriving after a packet's first byte and before its end or error strobe is ignored.
- R10: A byte written in the same cycle as `usb_pkt_end` is part of the packet being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_wr_en | input | 1 | Byte strobe from the serial engine |
| usb_wr_data | input | DATA_W | Received byte |
| usb_pkt_end | input | 1 | Packet closed successfully |
| usb_pkt_err | input | 1 | Packet closed with an error, discard it |
| usb_buf_avail | output | 1 | A free buffer waits for the next packet |
| cpu_rd_en | input | 1 | CPU read strobe |
| cpu_rd_data | output | DATA_W | Byte returned one cycle after the strobe |
| cpu_rx_size | output | CNT_W | Byte count of the packet in the viewed buffer |
| cpu_data_avail | output | 1 | The viewed buffer holds a packet |
| cpu_rd_err | output | 1 | Sticky over-read flag |
| cpu_rd_done | input | 1 | Read-finish trigger |
| fifo_clear | input | 1 | Empty both buffers when no packet is arriving |

## Verification
Four rules are checked by properties on every cycle. The size register never exceeds 64 and is zero whenever no data is shown. The size register stays put until a read-finish or a clear. The over-read flag, once set, holds and always comes with a zero data byte. An accepted clear always leaves the block empty.

Other behaviours need scripted scenarios to show them. These are:
- the order in which the two buffers are filled;
- the byte contents and their order;
- the NAK state dropping a whole packet;
- error-strobe recovery into the same buffer;
- truncation beyond 64 bytes;
- the ignored mid-packet clear;
- a read-finish with nothing to release.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;
  localparam int NUM_BUFS = 2;

  typedef logic buf_id_t;

  function automatic buf_id_t other_buf(input buf_id_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/pp_rx_store.sv
module pp_rx_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              rzero,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // simple dual-port array, no reset, so a block RAM can hold it
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port with a synchronous clear used for over-reads
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (re)    rdata <= mem[raddr];
    else if (rzero) rdata <= '0;
  end
endmodule

// File: rtl/pp_rx_fill.sv
module pp_rx_fill
  import pp_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7,
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                pkt_end,
  input  logic                pkt_err,
  input  logic                clr_ok,
  input  logic [NUM_BUFS-1:0] buf_full,
  output buf_id_t             fill_sel,
  output logic                busy,
  output logic                mem_we,
  output logic [IDX_W-1:0]    mem_widx,
  output logic                commit,
  output logic [CNT_W-1:0]    commit_cnt,
  output logic                avail
);
  logic [CNT_W-1:0] wr_cnt_q;
  buf_id_t          fill_sel_q;
  logic             busy_q;
  logic             room;
  logic             accept_wr;

  assign room       = !buf_full[fill_sel_q];
  assign accept_wr  = wr_en && !clr_ok && room && (wr_cnt_q < CNT_W'(DEPTH));
  assign commit     = pkt_end && !pkt_err && !clr_ok && room;
  assign commit_cnt = wr_cnt_q + CNT_W'(accept_wr);

  assign mem_we   = accept_wr;
  assign mem_widx = wr_cnt_q[IDX_W-1:0];
  assign fill_sel = fill_sel_q;
  assign busy     = busy_q;
  assign avail    = room;

  always_ff @(posedge clk) begin
    if (rst || clr_ok) begin
      fill_sel_q <= 1'b0;
      wr_cnt_q   <= '0;
      busy_q     <= 1'b0;
    end else if (pkt_err) begin
      wr_cnt_q <= '0;
      busy_q   <= 1'b0;
    end else if (commit) begin
      wr_cnt_q   <= '0;
      busy_q     <= 1'b0;
      fill_sel_q <= other_buf(fill_sel_q);
    end else if (accept_wr) begin
      wr_cnt_q <= wr_cnt_q + 1'b1;
      busy_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/pp_rx_bufstate.sv
module pp_rx_bufstate
  import pp_rx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr_ok,
  input  logic                           commit,
  input  buf_id_t                        commit_sel,
  input  logic [CNT_W-1:0]               commit_cnt,
  input  logic                           release_buf,
  input  buf_id_t                        release_sel,
  output logic [NUM_BUFS-1:0]            full_q,
  output logic [NUM_BUFS-1:0]            full_nx,
  output logic [NUM_BUFS-1:0][CNT_W-1:0] cnt_nx
);
  logic [NUM_BUFS-1:0][CNT_W-1:0] cnt_q;

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    localparam buf_id_t ME = buf_id_t'(b);

    always_comb begin
      full_nx[b] = full_q[b];
      cnt_nx[b]  = cnt_q[b];
      if (clr_ok) begin
        full_nx[b] = 1'b0;
        cnt_nx[b]  = '0;
      end else begin
        if (commit && commit_sel == ME) begin
          full_nx[b] = 1'b1;
          cnt_nx[b]  = commit_cnt;
        end
        if (release_buf && release_sel == ME) begin
          full_nx[b] = 1'b0;
          cnt_nx[b]  = '0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        full_q[b] <= 1'b0;
        cnt_q[b]  <= '0;
      end else begin
        full_q[b] <= full_nx[b];
        cnt_q[b]  <= cnt_nx[b];
      end
    end
  end
endmodule

// File: rtl/pp_rx_drain.sv
module pp_rx_drain
  import pp_rx_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int IDX_W = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  logic                           rd_done,
  input  logic                           clr_ok,
  input  logic [NUM_BUFS-1:0]            full_q,
  input  logic [NUM_BUFS-1:0]            full_nx,
  input  logic [NUM_BUFS-1:0][CNT_W-1:0] cnt_nx,
  output buf_id_t                        view_sel,
  output logic                           release_buf,
  output logic                           mem_re,
  output logic                           mem_rzero,
  output logic [IDX_W-1:0]               mem_ridx,
  output logic                           data_avail,
  output logic [CNT_W-1:0]               rx_size,
  output logic                           rd_err
);
  buf_id_t          view_q, view_nx;
  logic [CNT_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] size_q;
  logic             avail_q, err_q;
  logic             rd_ok, over;

  assign release_buf = rd_done && full_q[view_q] && !clr_ok;
  assign rd_ok       = rd_en && !clr_ok && avail_q && (rd_ptr_q < size_q);
  assign over        = rd_en && !clr_ok && !rd_ok;

  always_comb begin
    view_nx = view_q;
    if (clr_ok)           view_nx = 1'b0;
    else if (release_buf) view_nx = other_buf(view_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      view_q   <= 1'b0;
      rd_ptr_q <= '0;
      size_q   <= '0;
      avail_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      view_q  <= view_nx;
      avail_q <= full_nx[view_nx];
      size_q  <= full_nx[view_nx] ? cnt_nx[view_nx] : '0;
      if (clr_ok || release_buf) rd_ptr_q <= '0;
      else if (rd_ok)            rd_ptr_q <= rd_ptr_q + 1'b1;
      if (clr_ok || release_buf) err_q <= 1'b0;
      else if (over)             err_q <= 1'b1;
    end
  end

  assign view_sel   = view_q;
  assign mem_re     = rd_ok;
  assign mem_rzero  = over;
  assign mem_ridx   = rd_ptr_q[IDX_W-1:0];
  assign data_avail = avail_q;
  assign rx_size    = size_q;
  assign rd_err     = err_q;
endmodule

// File: rtl/ob_pingpong_rx.sv
module ob_pingpong_rx
  import pp_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usb_wr_en,
  input  logic [DATA_W-1:0] usb_wr_data,
  input  logic              usb_pkt_end,
  input  logic              usb_pkt_err,
  output logic              usb_buf_avail,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic [CNT_W-1:0]  cpu_rx_size,
  output logic              cpu_data_avail,
  output logic              cpu_rd_err,
  input  logic              cpu_rd_done,
  input  logic              fifo_clear
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ADDR_W = IDX_W + 1;

  logic                           pkt_busy;
  logic                           clr_ok;
  buf_id_t                        fill_sel, view_sel;
  logic                           mem_we, mem_re, mem_rzero;
  logic [IDX_W-1:0]               widx, ridx;
  logic                           commit, release_buf;
  logic [CNT_W-1:0]               commit_cnt;
  logic [NUM_BUFS-1:0]            full_q, full_nx;
  logic [NUM_BUFS-1:0][CNT_W-1:0] cnt_nx;

  // a clear is honoured only between packets
  assign clr_ok = fifo_clear && !pkt_busy;

  pp_rx_fill #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_fill (
    .clk(clk), .rst(rst), .wr_en(usb_wr_en), .pkt_end(usb_pkt_end),
    .pkt_err(usb_pkt_err), .clr_ok(clr_ok), .buf_full(full_q),
    .fill_sel(fill_sel), .busy(pkt_busy), .mem_we(mem_we), .mem_widx(widx),
    .commit(commit), .commit_cnt(commit_cnt), .avail(usb_buf_avail)
  );

  pp_rx_bufstate #(.CNT_W(CNT_W)) u_state (
    .clk(clk), .rst(rst), .clr_ok(clr_ok), .commit(commit),
    .commit_sel(fill_sel), .commit_cnt(commit_cnt),
    .release_buf(release_buf), .release_sel(view_sel),
    .full_q(full_q), .full_nx(full_nx), .cnt_nx(cnt_nx)
  );

  pp_rx_drain #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_drain (
    .clk(clk), .rst(rst), .rd_en(cpu_rd_en), .rd_done(cpu_rd_done),
    .clr_ok(clr_ok), .full_q(full_q), .full_nx(full_nx), .cnt_nx(cnt_nx),
    .view_sel(view_sel), .release_buf(release_buf), .mem_re(mem_re),
    .mem_rzero(mem_rzero), .mem_ridx(ridx), .data_avail(cpu_data_avail),
    .rx_size(cpu_rx_size), .rd_err(cpu_rd_err)
  );

  pp_rx_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .we(mem_we), .waddr({fill_sel, widx}),
    .wdata(usb_wr_data), .re(mem_re), .rzero(mem_rzero),
    .raddr({view_sel, ridx}), .rdata(cpu_rd_data)
  );
endmodule

// File: rtl/pp_rx_checker.sv
module pp_rx_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              usb_buf_avail,
  input logic              cpu_rd_en,
  input logic              cpu_rd_done,
  input logic              fifo_clear,
  input logic              cpu_data_avail,
  input logic [CNT_W-1:0]  cpu_rx_size,
  input logic              cpu_rd_err,
  input logic [DATA_W-1:0] cpu_rd_data,
  input logic              pkt_busy
);
  assert_size_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_rx_size <= CNT_W'(DEPTH));

  assert_empty_size_R2: assert property (@(posedge clk) disable iff (rst)
    !cpu_data_avail |-> cpu_rx_size == '0);

  assert_size_held_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_data_avail && !cpu_rd_done && !fifo_clear) |=> $stable(cpu_rx_size));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_err && !cpu_rd_done && !fifo_clear) |=> cpu_rd_err);

  assert_overread_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd_en && !cpu_data_avail && !fifo_clear) |=> (cpu_rd_err && cpu_rd_data == '0));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    (fifo_clear && !pkt_busy) |=>
      (usb_buf_avail && !cpu_data_avail && cpu_rx_size == '0 && !cpu_rd_err));
endmodule

bind ob_pingpong_rx pp_rx_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .usb_buf_avail(usb_buf_avail), .cpu_rd_en(cpu_rd_en),
  .cpu_rd_done(cpu_rd_done), .fifo_clear(fifo_clear),
  .cpu_data_avail(cpu_data_avail), .cpu_rx_size(cpu_rx_size),
  .cpu_rd_err(cpu_rd_err), .cpu_rd_data(cpu_rd_data), .pkt_busy(pkt_busy)
);

// File: tb/test_ob_pingpong_rx.sv
`timescale 1ns/1ps
module test_ob_pingpong_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       usb_wr_en = 1'b0;
  logic [7:0] usb_wr_data = '0;
  logic       usb_pkt_end = 1'b0;
  logic       usb_pkt_err = 1'b0;
  logic       usb_buf_avail;
  logic       cpu_rd_en = 1'b0;
  logic [7:0] cpu_rd_data;
  logic [6:0] cpu_rx_size;
  logic       cpu_data_avail;
  logic       cpu_rd_err;
  logic       cpu_rd_done = 1'b0;
  logic       fifo_clear = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic rd_seen = 1'b0;

  always #2 clk = ~clk;

  ob_pingpong_rx i_ob_pingpong_rx (
    .clk(clk), .rst(rst), .usb_wr_en(usb_wr_en), .usb_wr_data(usb_wr_data),
    .usb_pkt_end(usb_pkt_end), .usb_pkt_err(usb_pkt_err),
    .usb_buf_avail(usb_buf_avail), .cpu_rd_en(cpu_rd_en),
    .cpu_rd_data(cpu_rd_data), .cpu_rx_size(cpu_rx_size),
    .cpu_data_avail(cpu_data_avail), .cpu_rd_err(cpu_rd_err),
    .cpu_rd_done(cpu_rd_done), .fifo_clear(fifo_clear)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_view(input string tag, input bit av, input int size);
    chk(cpu_data_avail == av, {tag, " data_avail"}, int'(cpu_data_avail), int'(av));
    chk(int'(cpu_rx_size) == size, {tag, " rx_size"}, int'(cpu_rx_size), size);
  endtask

  // monitor: compare each returned byte one cycle after its read strobe
  always @(posedge clk) rd_seen <= cpu_rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected read data", int'(cpu_rd_data), -1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cpu_rd_data == e, t, int'(cpu_rd_data), int'(e));
      end
    end
  end

  task automatic beat(input logic [7:0] d, input bit last);
    @(negedge clk);
    usb_wr_en = 1'b1; usb_wr_data = d; usb_pkt_end = last;
  endtask

  task automatic idle_usb();
    @(negedge clk);
    usb_wr_en = 1'b0; usb_pkt_end = 1'b0; usb_pkt_err = 1'b0;
  endtask

  task automatic send_pkt(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) beat(seed + 8'(i), i == len - 1);
    idle_usb();
  endtask

  task automatic write_bytes(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) beat(seed + 8'(i), 1'b0);
    idle_usb();
  endtask

  task automatic strobe_err();
    @(negedge clk); usb_pkt_err = 1'b1;
    idle_usb();
  endtask

  // driver: issue reads and push expected bytes (0 beyond the valid count)
  task automatic read_n(input int n, input int valid, input logic [7:0] seed, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_rd_en = 1'b1;
      exp_q.push_back(i < valid ? seed + 8'(i) : 8'h00);
      tag_q.push_back(tag);
    end
    @(negedge clk); cpu_rd_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cpu_rd_done = 1'b1;
    @(negedge clk); cpu_rd_done = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); fifo_clear = 1'b1;
    @(negedge clk); fifo_clear = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(usb_buf_avail == 1'b1, "R1 buf_avail", int'(usb_buf_avail), 1);
    chk_view("R1", 1'b0, 0);
    chk(cpu_rd_err == 1'b0, "R1 rd_err", int'(cpu_rd_err), 0);

    // R2 first packet lands in buffer 0 and is read in order
    send_pkt(5, 8'h10);
    chk_view("R2 first packet", 1'b1, 5);
    read_n(5, 5, 8'h10, "R2 read data");
    chk(cpu_rd_err == 1'b0, "R2 no error after valid reads", int'(cpu_rd_err), 0);

    // R3 second packet fills buffer 1, view stays on first
    send_pkt(3, 8'h40);
    chk_view("R3 view held", 1'b1, 5);
    // R4 both buffers held: NAK state, packet discarded
    chk(usb_buf_avail == 1'b0, "R4 buf_avail low", int'(usb_buf_avail), 0);
    send_pkt(4, 8'hC0);
    chk_view("R4 ignored packet", 1'b1, 5);

    // R5 over-read of the sixth byte
    read_n(1, 0, 8'h00, "R5 over-read data");
    chk(cpu_rd_err == 1'b1, "R5 error raised", int'(cpu_rd_err), 1);
    @(negedge clk);
    chk(cpu_rd_err == 1'b1, "R5 error sticky", int'(cpu_rd_err), 1);

    // R6 read-finish switches view, R3 size of second packet loaded
    pulse_done();
    chk_view("R3 after read-finish", 1'b1, 3);
    chk(cpu_rd_err == 1'b0, "R5 error cleared by read-finish", int'(cpu_rd_err), 0);
    chk(usb_buf_avail == 1'b1, "R6 buffer freed", int'(usb_buf_avail), 1);
    read_n(3, 3, 8'h40, "R3 second packet data");
    pulse_done();
    chk_view("R4 discarded packet absent", 1'b0, 0);

    // R6 read-finish with nothing shown has no effect
    pulse_done();
    send_pkt(2, 8'h70);
    chk_view("R6 empty read-finish ignored", 1'b1, 2);
    read_n(2, 2, 8'h70, "R6 data");
    pulse_done();

    // R7 error strobe drops the packet, buffer 1 reused
    write_bytes(4, 8'hA0);
    strobe_err();
    chk_view("R7 dropped packet", 1'b0, 0);
    chk(usb_buf_avail == 1'b1, "R7 buffer free", int'(usb_buf_avail), 1);
    send_pkt(6, 8'h90);
    chk_view("R7 same buffer reused", 1'b1, 6);
    read_n(6, 6, 8'h90, "R7 data");
    pulse_done();

    // R8 oversize packet truncated to 64
    send_pkt(70, 8'h80);
    chk_view("R8 truncated size", 1'b1, 64);
    read_n(64, 64, 8'h80, "R8 data");
    pulse_done();

    // R10 byte with the end strobe is included
    write_bytes(2, 8'h30);
    beat(8'h32, 1'b1);
    idle_usb();
    chk_view("R10 size includes last byte", 1'b1, 3);
    read_n(3, 3, 8'h30, "R10 data");
    pulse_done();

    // R9 clear ignored mid-packet, honoured when idle
    send_pkt(4, 8'h50);
    write_bytes(2, 8'h60);
    pulse_clear();
    chk_view("R9 clear ignored mid-packet", 1'b1, 4);
    beat(8'h62, 1'b1);
    idle_usb();
    read_n(4, 4, 8'h50, "R9 first packet data");
    pulse_done();
    chk_view("R9 packet survived clear", 1'b1, 3);
    read_n(4, 3, 8'h60, "R9 second packet data");
    chk(cpu_rd_err == 1'b1, "R5 error before clear", int'(cpu_rd_err), 1);
    pulse_clear();
    chk_view("R9 cleared", 1'b0, 0);
    chk(cpu_rd_err == 1'b0, "R9 error cleared", int'(cpu_rd_err), 0);
    chk(usb_buf_avail == 1'b1, "R9 buf_avail", int'(usb_buf_avail), 1);
    send_pkt(2, 8'hE0);
    chk_view("R9 restart at buffer 0", 1'b1, 2);
    read_n(2, 2, 8'hE0, "R9 restart data");

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule